// File: doc/BRIEF.md
# Indexed Register and Memory Access Window

This block is a small host-facing front end that reaches a large address space through a narrow window. The host first writes a 32-bit pointer into an index register, then reads or writes one of four data-window bytes. The top bit of the pointer chooses the destination. When it is set, the access goes to a video memory request port. When it is clear, the access goes to a register-file request port. Accesses that would run past the end of memory are suppressed, and so are accesses whose pointer would point back into the window itself. A sticky error flag records each suppressed access, and reading the flag clears it.

The host bus carries a one-cycle command strobe with a byte offset and an access size. The size code is 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. Data is right-aligned and little-endian. The block handles one command at a time. It holds a request on the chosen target port until that target acknowledges, then gives the host a one-cycle ready pulse with the read data.

Top module: `idx_window`

## Requirements
- R1: A host write to any byte of offsets 0–3 loads the whole 32-bit write data into the index with bits [1:0] forced to 0. A read of offsets 0–3 returns the whole stored index, whatever the size.
- R2: An access to offsets 4–7 is forwarded with the host size unchanged. Its target address is the index plus host address bits [1:0]. For memory, index bit 31 is taken as 0 before the add.
- R3: When index bit 31 is 1, the window access goes out on the memory port only. Write data on the port keeps only the bytes inside the access size, and the upper bytes are zero. Read data is returned with byte 0 in bits [7:0], and bytes beyond the size are returned as 0.
- R4: A memory access is issued only if its address plus its byte count is at most MEM_BYTES. Otherwise no request is made, and a read returns 0.
- R5: When index bit 31 is 0 and the index is greater than 7, the window access goes out on the register port only, at the index plus the byte offset. Read data is masked to the size.
- R6: When index bit 31 is 0 and the index is 7 or less, no request is made, and a read returns 0.
- R7: Each access suppressed under R4 or R6 sets an error flag. A read of offsets 8–11 returns the flag in bit 0, with every other bit 0, and clears the flag. Writes to offsets 8–11 change nothing.
- R8: A target request stays high, with address and data stable, until its acknowledge. hostReady pulses for one cycle in the cycle after the acknowledge is sampled. An access that is not forwarded pulses hostReady in the cycle after its strobe. Write responses carry 0 data.
- R9: A host strobe that arrives while a command is still in progress is ignored.
- R10: Offsets 12–15 read as 0. Writes to them have no effect, and they do not set the error flag.
- R11: After reset the index and the error flag are 0, and no request or ready is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | One-cycle command strobe |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | HOST_AW | Byte offset within the block |
| hostSize | input | 2 | Access size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| hostWdata | input | 32 | Right-aligned write data |
| hostReady | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read data, valid with hostReady |
| memReq | output | 1 | Memory request, held until memAck |
| memWrite | output | 1 | Memory write flag |
| memAddr | output | 32 | Memory byte address |
| memSize | output | 2 | Memory access size code |
| memWdata | output | 32 | Memory write data, little-endian |
| memAck | input | 1 | Memory acknowledge |
| memRdata | input | 32 | Memory read data, little-endian |
| regReq | output | 1 | Register request, held until regAck |
| regWrite | output | 1 | Register write flag |
| regAddr | output | 32 | Register byte address |
| regSize | output | 2 | Register access size code |
| regWdata | output | 32 | Register write data |
| regAck | input | 1 | Register acknowledge |
| regRdata | input | 32 | Register read data |

## Verification
Two events can land in one cycle: a target acknowledge closing a forwarded access, and a fresh host strobe. To provoke this, the bench's memory responder raises a host index-write strobe in the very cycle it raises memAck. The outcome is judged by reading the index back afterwards: it must still hold its earlier value. A per-clock routing monitor must also see no extra request. Latency, data and port fields of every access are compared against a behavioural model of the index, the error flag and the target storage.

// File: rtl/idxwin_pkg.sv
`timescale 1ns/1ps
package idxwin_pkg;
  typedef enum logic [2:0] {
    KIND_INDEX, KIND_WIN_MEM, KIND_WIN_REG, KIND_WIN_BAD, KIND_STATUS, KIND_NONE
  } accKind_e;

  typedef enum logic [2:0] {
    RD_KEEP, RD_ZERO, RD_INDEX, RD_STATUS, RD_TARGET
  } rdSel_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_WAIT_MEM, ST_WAIT_REG, ST_RESP
  } ctlState_e;

  typedef struct packed {
    logic   acceptCmd;
    logic   loadIndex;
    logic   setErr;
    logic   clrErr;
    rdSel_e rdSel;
  } dpStrobe_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] sizeMask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/idxwin_datapath.sv
`timescale 1ns/1ps
module idxwin_datapath
  import idxwin_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4096,
  parameter int unsigned HOST_AW   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                hostWrite,
  input  logic [HOST_AW-1:0]  hostAddr,
  input  logic [1:0]          hostSize,
  input  logic [31:0]         hostWdata,
  input  logic [31:0]         memRdata,
  input  logic [31:0]         regRdata,
  output accKind_e            kind,
  output logic                cmdWrite,
  output logic [1:0]          cmdSize,
  output logic [31:0]         cmdAddr,
  output logic [31:0]         cmdWdata,
  output logic [31:0]         hostRdata
);
  localparam int unsigned      SEL_W     = HOST_AW - 2;
  localparam logic [SEL_W-1:0] SEL_INDEX = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_WIN   = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_STAT  = SEL_W'(2);
  localparam logic [31:0]      WIN_LAST  = 32'(4 * SEL_WIN + 3);
  localparam logic [32:0]      MEM_LIMIT = 33'(MEM_BYTES);

  logic [31:0]      indexQ;
  logic             errQ;
  logic             cmdIsMem;
  logic [SEL_W-1:0] wordSel;
  logic [31:0]      winOff, memAddrC, regAddrC;
  logic             memFits;

  // Decode of the incoming command against the current index
  always_comb begin
    wordSel  = hostAddr[HOST_AW-1:2];
    winOff   = {30'b0, hostAddr[1:0]};
    memAddrC = {1'b0, indexQ[30:0]} + winOff;
    regAddrC = indexQ + winOff;
    memFits  = ({1'b0, memAddrC} + {30'b0, sizeBytes(hostSize)}) <= MEM_LIMIT;
    if (wordSel == SEL_INDEX)      kind = KIND_INDEX;
    else if (wordSel == SEL_STAT)  kind = KIND_STATUS;
    else if (wordSel != SEL_WIN)   kind = KIND_NONE;
    else if (indexQ[31])           kind = memFits ? KIND_WIN_MEM : KIND_WIN_BAD;
    else if (indexQ > WIN_LAST)    kind = KIND_WIN_REG;
    else                           kind = KIND_WIN_BAD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ    <= '0;
      errQ      <= 1'b0;
      cmdIsMem  <= 1'b0;
      cmdWrite  <= 1'b0;
      cmdSize   <= '0;
      cmdAddr   <= '0;
      cmdWdata  <= '0;
      hostRdata <= '0;
    end else begin
      if (strobe.loadIndex) indexQ <= {hostWdata[31:2], 2'b00};
      if (strobe.setErr)      errQ <= 1'b1;
      else if (strobe.clrErr) errQ <= 1'b0;
      if (strobe.acceptCmd) begin
        cmdWrite <= hostWrite;
        cmdSize  <= hostSize;
        cmdWdata <= hostWdata & sizeMask(hostSize);
        cmdIsMem <= indexQ[31];
        cmdAddr  <= indexQ[31] ? memAddrC : regAddrC;
      end
      case (strobe.rdSel)
        RD_ZERO:   hostRdata <= '0;
        RD_INDEX:  hostRdata <= indexQ;
        RD_STATUS: hostRdata <= {31'b0, errQ};
        RD_TARGET: hostRdata <= cmdWrite ? '0 :
                                ((cmdIsMem ? memRdata : regRdata) & sizeMask(cmdSize));
        default:   ;
      endcase
    end
  end

  // R1
  index_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadIndex |=> (indexQ[1:0] == 2'b00));
endmodule

// File: rtl/idxwin_ctrl.sv
`timescale 1ns/1ps
module idxwin_ctrl
  import idxwin_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostValid,
  input  logic      hostWrite,
  input  accKind_e  kind,
  input  logic      memAck,
  input  logic      regAck,
  output dpStrobe_t strobe,
  output logic      memReq,
  output logic      regReq,
  output logic      hostReady
);
  ctlState_e stQ, stD;

  always_comb begin
    stD          = stQ;
    strobe       = '0;
    strobe.rdSel = RD_KEEP;
    case (stQ)
      ST_IDLE: if (hostValid) begin
        strobe.acceptCmd = 1'b1;
        strobe.rdSel     = RD_ZERO;
        stD              = ST_RESP;
        case (kind)
          KIND_INDEX:   if (hostWrite) strobe.loadIndex = 1'b1;
                        else           strobe.rdSel     = RD_INDEX;
          KIND_STATUS:  if (!hostWrite) begin
                          strobe.rdSel  = RD_STATUS;
                          strobe.clrErr = 1'b1;
                        end
          KIND_WIN_MEM: begin stD = ST_WAIT_MEM; strobe.rdSel = RD_KEEP; end
          KIND_WIN_REG: begin stD = ST_WAIT_REG; strobe.rdSel = RD_KEEP; end
          KIND_WIN_BAD: strobe.setErr = 1'b1;
          default:      ;
        endcase
      end
      ST_WAIT_MEM: if (memAck) begin strobe.rdSel = RD_TARGET; stD = ST_RESP; end
      ST_WAIT_REG: if (regAck) begin strobe.rdSel = RD_TARGET; stD = ST_RESP; end
      default:     stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  assign memReq    = (stQ == ST_WAIT_MEM);
  assign regReq    = (stQ == ST_WAIT_REG);
  assign hostReady = (stQ == ST_RESP);

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);
endmodule

// File: rtl/idx_window.sv
`timescale 1ns/1ps
module idx_window
  import idxwin_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4096,
  parameter int unsigned HOST_AW   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [1:0]         hostSize,
  input  logic [31:0]        hostWdata,
  output logic               hostReady,
  output logic [31:0]        hostRdata,
  output logic               memReq,
  output logic               memWrite,
  output logic [31:0]        memAddr,
  output logic [1:0]         memSize,
  output logic [31:0]        memWdata,
  input  logic               memAck,
  input  logic [31:0]        memRdata,
  output logic               regReq,
  output logic               regWrite,
  output logic [31:0]        regAddr,
  output logic [1:0]         regSize,
  output logic [31:0]        regWdata,
  input  logic               regAck,
  input  logic [31:0]        regRdata
);
  localparam logic [31:0] WIN_LAST  = 32'd7;
  localparam logic [32:0] MEM_LIMIT = 33'(MEM_BYTES);

  dpStrobe_t   strobe;
  accKind_e    kind;
  logic        cmdWrite;
  logic [1:0]  cmdSize;
  logic [31:0] cmdAddr, cmdWdata;

  idxwin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .kind(kind), .memAck(memAck), .regAck(regAck), .strobe(strobe),
    .memReq(memReq), .regReq(regReq), .hostReady(hostReady)
  );

  idxwin_datapath #(.MEM_BYTES(MEM_BYTES), .HOST_AW(HOST_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .memRdata(memRdata), .regRdata(regRdata), .kind(kind),
    .cmdWrite(cmdWrite), .cmdSize(cmdSize), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .hostRdata(hostRdata)
  );

  assign memWrite = cmdWrite;
  assign memAddr  = cmdAddr;
  assign memSize  = cmdSize;
  assign memWdata = cmdWdata;
  assign regWrite = cmdWrite;
  assign regAddr  = cmdAddr;
  assign regSize  = cmdSize;
  assign regWdata = cmdWdata;

  // R4
  mem_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (({1'b0, memAddr} + {30'b0, sizeBytes(memSize)}) <= MEM_LIMIT));

  // R5
  reg_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    regReq |-> (regAddr > WIN_LAST));

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWdata)));

  // R8
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> (regReq && $stable(regAddr) && $stable(regWdata)));

  // R3
  excl_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && regReq));
endmodule

// File: tb/idx_window_tb_top.sv
`timescale 1ns/1ps
module idx_window_tb_top;
  localparam int unsigned MEMB = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        hostValid, hostWrite, hostReady;
  logic [3:0]  hostAddr;
  logic [1:0]  hostSize;
  logic [31:0] hostWdata, hostRdata;
  logic        memReq, memWrite, memAck, regReq, regWrite, regAck;
  logic [31:0] memAddr, memWdata, memRdata, regAddr, regWdata, regRdata;
  logic [1:0]  memSize, regSize;

  idx_window #(.MEM_BYTES(MEMB), .HOST_AW(4)) dut_i (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostReady(hostReady), .hostRdata(hostRdata),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr), .regSize(regSize),
    .regWdata(regWdata), .regAck(regAck), .regRdata(regRdata)
  );

  int tests = 0, fails = 0;
  logic [7:0]  benchMem [MEMB];
  logic [31:0] regStore [logic [31:0]];
  int memDelay = 0, regDelay = 0, memCnt = 0, regCnt = 0, memHits = 0, regHits = 0;
  int expTgt = 0;
  logic [31:0] gotAddr, gotWdata;
  logic [1:0]  gotSize;
  logic        gotWrite;
  logic [31:0] mIndex = '0;
  logic        mErr = 1'b0;
  logic        injectArm = 1'b0, injectLive = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] regDefault(input logic [31:0] a);
    return 32'h5A00_0000 ^ a;
  endfunction

  function automatic int nBytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  // Target responders and ack-cycle strobe injection
  always @(negedge clk) begin
    if (injectLive) begin hostValid = 1'b0; injectLive = 1'b0; end
    if (memAck) begin memAck = 1'b0; memCnt = 0; end
    else if (memReq) begin
      if (memCnt == memDelay) begin
        memHits++;
        gotAddr = memAddr; gotSize = memSize; gotWrite = memWrite; gotWdata = memWdata;
        memRdata = 32'hEEEE_EEEE;
        for (int i = 0; i < nBytes(memSize); i++) begin
          if (memWrite) benchMem[memAddr + i] = memWdata[8*i +: 8];
          else          memRdata[8*i +: 8] = benchMem[memAddr + i];
        end
        memAck = 1'b1;
        if (injectArm) begin
          injectArm = 1'b0; injectLive = 1'b1;
          hostValid = 1'b1; hostWrite = 1'b1; hostAddr = 4'h0; hostSize = 2'd2;
          hostWdata = 32'hDEAD_BEE0;
        end
      end else memCnt++;
    end
    if (regAck) begin regAck = 1'b0; regCnt = 0; end
    else if (regReq) begin
      if (regCnt == regDelay) begin
        regHits++;
        gotAddr = regAddr; gotSize = regSize; gotWrite = regWrite; gotWdata = regWdata;
        if (regWrite) regStore[regAddr] = regWdata;
        regRdata = regStore.exists(regAddr) ? regStore[regAddr] : regDefault(regAddr);
        regAck = 1'b1;
      end else regCnt++;
    end
  end

  // Per-clock routing comparison against the model's expected target (R3, R5)
  always @(negedge clk) begin
    if (rstN)
      chk(!(memReq && regReq) && (!memReq || expTgt == 1) && (!regReq || expTgt == 2),
          "R3 R5 per-cycle routing", {30'b0, memReq, regReq}, expTgt);
  end

  task automatic acc(input string req, input bit wr, input logic [3:0] a,
                     input logic [1:0] sz, input logic [31:0] wd, input int dly);
    logic [31:0] expData, expAddr, tgtAddr, mask;
    int nb, tgt, memH0, regH0, lat;
    nb = nBytes(sz);
    mask = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    tgt = 0; expData = '0; expAddr = '0;
    case (a[3:2])
      2'd0: if (wr) mIndex = wd & 32'hFFFF_FFFC; else expData = mIndex;
      2'd1: begin
        if (mIndex[31]) begin
          tgtAddr = {1'b0, mIndex[30:0]} + {30'b0, a[1:0]};
          if (tgtAddr + nb <= MEMB) begin
            tgt = 1; expAddr = tgtAddr;
            if (!wr) for (int i = 0; i < nb; i++) expData[8*i +: 8] = benchMem[tgtAddr + i];
          end else mErr = 1'b1;
        end else if (mIndex > 32'd7) begin
          tgt = 2; expAddr = mIndex + {30'b0, a[1:0]};
          if (!wr) expData = (regStore.exists(expAddr) ? regStore[expAddr] : regDefault(expAddr)) & mask;
        end else mErr = 1'b1;
      end
      2'd2: if (!wr) begin expData = {31'b0, mErr}; mErr = 1'b0; end
      default: ;
    endcase
    memH0 = memHits; regH0 = regHits;
    memDelay = dly; regDelay = dly; expTgt = tgt;
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostAddr = a; hostSize = sz; hostWdata = wd;
    @(negedge clk);
    hostValid = 1'b0; lat = 1;
    while (!hostReady && lat < 100) begin @(negedge clk); lat++; end
    chk(lat == ((tgt == 0) ? 1 : 2 + dly), {req, " R8 latency"}, lat, (tgt == 0) ? 1 : 2 + dly);
    chk(hostRdata == expData, {req, " data"}, hostRdata, expData);
    if (tgt == 1)
      chk(memHits == memH0 + 1 && gotAddr == expAddr && gotSize == sz && gotWrite == wr &&
          (!wr || gotWdata == (wd & mask)), {req, " R2 memory request"}, gotAddr, expAddr);
    else if (tgt == 2)
      chk(regHits == regH0 + 1 && gotAddr == expAddr && gotSize == sz && gotWrite == wr &&
          (!wr || gotWdata == (wd & mask)), {req, " R5 register request"}, gotAddr, expAddr);
    else
      chk(memHits == memH0 && regHits == regH0, {req, " no request"}, memHits + regHits, memH0 + regH0);
    expTgt = 0;
  endtask

  initial begin
    hostValid = 0; hostWrite = 0; hostAddr = 0; hostSize = 0; hostWdata = 0;
    memAck = 0; regAck = 0; memRdata = 0; regRdata = 0;
    for (int i = 0; i < MEMB; i++) benchMem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(!hostReady && !memReq && !regReq, "R11 outputs in reset",
        {29'b0, hostReady, memReq, regReq}, 32'h0);
    rstN = 1'b1;
    acc("R11 index after reset", 0, 4'h0, 2'd2, 0, 0);
    acc("R11 flag after reset", 0, 4'h8, 2'd2, 0, 0);
    acc("R1 index write", 1, 4'h0, 2'd2, 32'h8000_0013, 0);
    acc("R1 index read", 0, 4'h0, 2'd2, 0, 0);
    acc("R1 byte-offset index write", 1, 4'h2, 2'd0, 32'h1234_5677, 0);
    acc("R1 byte-size index read", 0, 4'h1, 2'd0, 0, 0);
    acc("R1 set memory index", 1, 4'h0, 2'd2, 32'h8000_0010, 0);
    acc("R3 memory word write", 1, 4'h4, 2'd2, 32'h4433_2211, 1);
    acc("R2 memory byte read offset 1", 0, 4'h5, 2'd0, 0, 0);
    acc("R2 memory half read offset 2", 0, 4'h6, 2'd1, 0, 2);
    acc("R3 memory word read", 0, 4'h4, 2'd2, 0, 3);
    acc("R3 memory byte write offset 3", 1, 4'h7, 2'd0, 32'hFFFF_FFAB, 0);
    acc("R3 memory word readback", 0, 4'h4, 2'd3, 0, 1);
    acc("R4 set end index", 1, 4'h0, 2'd2, 32'h8000_00FC, 0);
    acc("R4 last word fits", 0, 4'h4, 2'd2, 0, 0);
    acc("R4 word past end", 0, 4'h5, 2'd2, 0, 0);
    acc("R4 last byte fits", 1, 4'h7, 2'd0, 32'h0000_0077, 1);
    acc("R4 half past end", 1, 4'h7, 2'd1, 32'h0000_1111, 0);
    acc("R7 flag set", 0, 4'h8, 2'd2, 0, 0);
    acc("R7 flag cleared by read", 0, 4'hA, 2'd0, 0, 0);
    acc("R5 set register index", 1, 4'h0, 2'd2, 32'h0000_0008, 0);
    acc("R5 register half write", 1, 4'h6, 2'd1, 32'hCAFE_1234, 1);
    acc("R5 register half readback", 0, 4'h6, 2'd1, 0, 0);
    acc("R5 register word default", 0, 4'h4, 2'd2, 0, 2);
    acc("R6 set small index", 1, 4'h0, 2'd2, 32'h0000_0007, 0);
    acc("R6 small index read", 0, 4'h5, 2'd2, 0, 0);
    acc("R6 small index write", 1, 4'h4, 2'd2, 32'h1, 0);
    acc("R7 flag write ignored", 1, 4'h8, 2'd2, 32'h0, 0);
    acc("R7 flag kept", 0, 4'h8, 2'd2, 0, 0);
    acc("R10 unmapped write", 1, 4'hC, 2'd2, 32'hFFFF_FFFF, 0);
    acc("R10 unmapped read", 0, 4'hF, 2'd0, 0, 0);
    acc("R10 no flag from unmapped", 0, 4'h8, 2'd2, 0, 0);
    acc("R9 set memory index", 1, 4'h0, 2'd2, 32'h8000_0020, 0);
    injectArm = 1'b1;
    acc("R9 access with ack-cycle strobe", 0, 4'h4, 2'd2, 0, 2);
    chk(!injectArm, "R9 strobe injected", {31'b0, injectArm}, 32'h0);
    acc("R9 index unchanged", 0, 4'h0, 2'd2, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog R8 actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule